// File: doc/BRIEF.md
# Serial-Data Modulated Dual-Compare Timer

This block turns a slow serial bit stream into a modulated waveform for a transmitter stage. It has an 8-bit up-counter that advances on a count-enable tick, two compare registers, a small control word per compare register, and one toggle flip-flop that drives the output. A serial data bit from an external shift register steers the output in one of three operating modes.

In carrier-burst mode, compare register A sets a fixed carrier and the data bit gates it. In FSK mode, the data bit picks which compare register sets the toggle period, so the line carries one of two frequencies. In pulse-width mode, an external restart trigger starts each bit period with the output high, and the data bit picks which compare register ends the pulse. The data bit is captured only at a counter wrap or at a restart, so a bit change never cuts a period short. The shift register and the baud-rate source are outside the block.

Top module: `sdm_timer`

## Requirements
- R1: The counter advances only in cycles where `tick` is high. With a tick every second cycle, every output interval is twice as long in clock cycles as with a tick every cycle.
- R2: The output flip-flop flips only on an effective match of a compare register whose toggle bit (`cfg_x[0]`) is set. With that bit clear, the output holds its level while matches still occur.
- R3: When the active compare register has its clear bit (`cfg_x[1]`) set, the counter goes back to 0 on the tick after it equals that compare value. With toggle and clear set, each output half period is compare value + 1 ticks.
- R4: In FSK mode (`mode_sel` = 2), a latched data bit of 0 makes register A active and a latched bit of 1 makes register B active.
- R5: In carrier-burst mode (`mode_sel` = 1), only register A acts. A latched data bit of 1 passes the carrier and a latched bit of 0 holds `mod_out` low.
- R6: In pulse-width mode (`mode_sel` = 3), `restart` clears the counter and sets the output high on the next edge. `restart` wins over a tick in the same cycle. The output falls after compare value + 1 ticks of the register chosen by the data bit (0 selects A, 1 selects B).
- R7: When a compare register has its single-action bit (`cfg_x[2]`) set, it acts at most once between restarts. Later equal counts give no toggle, no clear and no strobe.
- R8: The data bit is latched only at a counter wrap (a clear on match, or an overflow from 255 to 0) or at a restart. A change in mid-period leaves the current period as it was.
- R9: `match_a` and `match_b` each pulse for one cycle on the same edge as the action of their register's effective match. They are never high together, and the inactive register never pulses.
- R10: A synchronous reset clears the counter, the flip-flop, the single-action flags, the strobes and the registered mode. Mode 0 (off) holds the counter at 0 and `mod_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable from the chosen clock source |
| restart | input | 1 | Restart trigger: clears the counter and starts a bit period |
| ser_bit | input | 1 | Serial data bit from the shift register |
| mode_sel | input | 2 | 0 off, 1 carrier burst, 2 FSK, 3 pulse width |
| cmp_a | input | 8 | Compare value A |
| cmp_b | input | 8 | Compare value B |
| cfg_a | input | 3 | Controls for A: [0] toggle, [1] clear, [2] single action |
| cfg_b | input | 3 | Controls for B, same layout |
| mod_out | output | 1 | Modulated output |
| match_a | output | 1 | Strobe for an effective match of A |
| match_b | output | 1 | Strobe for an effective match of B |

## Verification
The bench sweeps compare pairs in FSK mode and measures every half period. It changes the data bit in mid-period and also on every edge in an alternating pattern. A design that latched the bit at once would return a shortened or swapped interval. Pulse widths are measured after each restart, with the data bit flipped right after the trigger, and the output is then watched for the rest of the period. Here a missing single-action flag shows up as a second edge, and a missing restart priority shows up as a width that is one tick short. A run of more than two counter laps checks that the overflow wrap does not re-arm a single-action compare. The burst test looks for any high sample while the gate is closed.

// File: rtl/sdm_timer_pkg.sv
package sdm_timer_pkg;

    localparam int CNT_W_DEF = 8;
    localparam int NUM_CMP   = 2;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_BURST = 2'd1,
        MODE_FSK   = 2'd2,
        MODE_PWM   = 2'd3
    } sdm_mode_e;

    // Per-compare control word: bit 0 toggle, bit 1 clear, bit 2 single action
    typedef struct packed {
        logic single;
        logic clr;
        logic tog;
    } sdm_cmpcfg_t;

    // Which compare registers may act in a mode (bit 0 = A, bit 1 = B)
    function automatic logic [NUM_CMP-1:0] active_sel(sdm_mode_e m, logic d);
        logic [NUM_CMP-1:0] r;
        case (m)
            MODE_BURST:         r = 2'b01;
            MODE_FSK, MODE_PWM: r = d ? 2'b10 : 2'b01;
            default:            r = 2'b00;
        endcase
        return r;
    endfunction

    // Output gating per mode
    function automatic logic gate_out(sdm_mode_e m, logic tff, logic d);
        logic r;
        case (m)
            MODE_BURST:         r = tff & d;
            MODE_FSK, MODE_PWM: r = tff;
            default:            r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sdm_counter.sv
module sdm_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         restart,
    input  logic         tick,
    input  logic         clear_req,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] CNT_MAX = '1;

    // A wrap is any return to zero caused by counting
    assign wrap = tick && !restart && !hold && (clear_req || (cnt == CNT_MAX));

    always_ff @(posedge clk) begin
        if (rst || hold || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= clear_req ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sdm_cmp_unit.sv
module sdm_cmp_unit
    import sdm_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         restart,
    input  logic         tick,
    input  logic         active,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  sdm_cmpcfg_t  cfg,
    output logic         tog_req,
    output logic         clr_req,
    output logic         strobe,
    output logic         fired
);
    logic eff;

    assign eff = tick && !restart && !hold && active &&
                 (cnt == cmp) && !(cfg.single && fired);
    assign tog_req = eff && cfg.tog;
    assign clr_req = eff && cfg.clr;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            fired  <= 1'b0;
            strobe <= 1'b0;
        end else begin
            strobe <= eff;
            if (restart) begin
                fired <= 1'b0;
            end else if (eff && cfg.single) begin
                fired <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sdm_outgen.sv
module sdm_outgen
    import sdm_timer_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sdm_mode_e mode,
    input  logic      restart,
    input  logic      tog_req,
    input  logic      wrap,
    input  logic      ser_bit,
    output logic      ser_q,
    output logic      tff,
    output logic      mod_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ser_q <= 1'b0;
            tff   <= 1'b0;
        end else if (mode == MODE_OFF) begin
            tff   <= 1'b0;
            ser_q <= ser_bit;
        end else if (restart) begin
            ser_q <= ser_bit;
            if (mode == MODE_PWM) begin
                tff <= 1'b1;
            end
        end else begin
            if (tog_req) begin
                tff <= ~tff;
            end
            if (wrap) begin
                ser_q <= ser_bit;
            end
        end
    end

    assign mod_out = gate_out(mode, tff, ser_q);
endmodule

// File: rtl/sdm_timer.sv
module sdm_timer
    import sdm_timer_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    input  logic             ser_bit,
    input  logic [1:0]       mode_sel,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [2:0]       cfg_a,
    input  logic [2:0]       cfg_b,
    output logic             mod_out,
    output logic             match_a,
    output logic             match_b
);
    sdm_mode_e          mode_q;
    logic               hold;
    logic [CNT_W-1:0]   cnt;
    logic               wrap;
    logic               ser_q;
    logic               tff;
    logic [NUM_CMP-1:0] act_vec;
    logic [NUM_CMP-1:0] tog_vec;
    logic [NUM_CMP-1:0] clr_vec;
    logic [NUM_CMP-1:0] stb_vec;
    logic [NUM_CMP-1:0] fired;
    logic [CNT_W-1:0]   cmp_arr [NUM_CMP];
    sdm_cmpcfg_t        cfg_arr [NUM_CMP];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_OFF;
        end else begin
            mode_q <= sdm_mode_e'(mode_sel);
        end
    end

    assign hold       = (mode_q == MODE_OFF);
    assign act_vec    = active_sel(mode_q, ser_q);
    assign cmp_arr[0] = cmp_a;
    assign cmp_arr[1] = cmp_b;
    assign cfg_arr[0] = sdm_cmpcfg_t'(cfg_a);
    assign cfg_arr[1] = sdm_cmpcfg_t'(cfg_b);

    sdm_counter #(.W(CNT_W)) cnt_i (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold),
        .restart   (restart),
        .tick      (tick),
        .clear_req (|clr_vec),
        .cnt       (cnt),
        .wrap      (wrap)
    );

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        sdm_cmp_unit #(.W(CNT_W)) cmp_i (
            .clk     (clk),
            .rst     (rst),
            .hold    (hold),
            .restart (restart),
            .tick    (tick),
            .active  (act_vec[i]),
            .cnt     (cnt),
            .cmp     (cmp_arr[i]),
            .cfg     (cfg_arr[i]),
            .tog_req (tog_vec[i]),
            .clr_req (clr_vec[i]),
            .strobe  (stb_vec[i]),
            .fired   (fired[i])
        );
    end

    sdm_outgen out_i (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode_q),
        .restart (restart),
        .tog_req (^tog_vec),
        .wrap    (wrap),
        .ser_bit (ser_bit),
        .ser_q   (ser_q),
        .tff     (tff),
        .mod_out (mod_out)
    );

    assign match_a = stb_vec[0];
    assign match_b = stb_vec[1];
endmodule

// File: rtl/sdm_timer_chk.sv
module sdm_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             restart,
    input logic [1:0]       mode_q,
    input logic [CNT_W-1:0] cnt,
    input logic             ser_q,
    input logic             wrap,
    input logic [1:0]       fired,
    input logic [2:0]       cfg_a,
    input logic             mod_out,
    input logic             match_a,
    input logic             match_b
);
    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({match_a, match_b}));

    // R6
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

    // R2
    edge_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd2 && $past(mode_q) == 2'd2 && !$past(restart) &&
         mod_out != $past(mod_out)) |-> (match_a || match_b));

    // R8
    ser_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q != 2'd0 && !restart && !wrap) |=> $stable(ser_q));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cnt == '0 && !mod_out && !match_a && !match_b));

    // R7
    single_once_chk: assert property (@(posedge clk) disable iff (rst)
        (fired[0] && cfg_a[2] && !restart) |=> !match_a);
endmodule

bind sdm_timer sdm_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .mode_q  (mode_q),
    .cnt     (cnt),
    .ser_q   (ser_q),
    .wrap    (wrap),
    .fired   (fired),
    .cfg_a   (cfg_a),
    .mod_out (mod_out),
    .match_a (match_a),
    .match_b (match_b)
);

// File: tb/sdm_timer_tb.sv
module sdm_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b1;
    logic       slow = 1'b0;
    logic       restart = 1'b0;
    logic       ser_bit = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic [7:0] cmp_a = 8'd0;
    logic [7:0] cmp_b = 8'd0;
    logic [2:0] cfg_a = 3'b000;
    logic [2:0] cfg_b = 3'b000;
    logic       mod_out, match_a, match_b;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) tick <= slow ? ~tick : 1'b1;

    sdm_timer dut_i (
        .clk(clk), .rst(rst), .tick(tick), .restart(restart), .ser_bit(ser_bit),
        .mode_sel(mode_sel), .cmp_a(cmp_a), .cmp_b(cmp_b), .cfg_a(cfg_a),
        .cfg_b(cfg_b), .mod_out(mod_out), .match_a(match_a), .match_b(match_b)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    // Cycles until mod_out changes, with strobe counts in that window
    task automatic gap(output int g, output int na, output int nb);
        logic p;
        p = mod_out; g = 0; na = 0; nb = 0;
        do begin
            @(negedge clk);
            g++;
            na += int'(match_a);
            nb += int'(match_b);
        end while (mod_out == p && g < 2000);
    endtask

    task automatic go_mode(input logic [1:0] m);
        mode_sel = 2'd0;
        repeat (3) @(negedge clk);
        mode_sel = m;
        @(negedge clk);
    endtask

    task automatic pulse_restart();
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
    endtask

    task automatic pwm_bit(input logic s, input bit flip, input int ca, input int cb);
        int w, hi;
        ser_bit = s;
        @(negedge clk);
        pulse_restart();
        if (flip) ser_bit = ~s;
        w = 0;
        while (mod_out && w < 300) begin
            w++;
            @(negedge clk);
        end
        chk(w == (s ? cb : ca) + 1, flip ? "R8 pwm width after late flip" : "R6 pwm width", w, (s ? cb : ca) + 1);
        hi = 0;
        repeat (25) begin
            @(negedge clk);
            hi += int'(mod_out);
        end
        chk(hi == 0, "R7 pwm stays low after single action", hi, 0);
    endtask

    initial begin
        #(CLK_PERIOD * WD_CYCLES);
        total++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int g, na, nb, latched, edges, hi, nma;
        logic pv;

        // R10 reset state
        repeat (3) @(negedge clk);
        chk(!mod_out && !match_a && !match_b, "R10 reset outputs", int'(mod_out), 0);
        rst = 1'b0;

        // R3 R4 R9 FSK sweep
        cfg_a = 3'b011; cfg_b = 3'b011;
        for (int ca = 1; ca <= 6; ca++) begin
            cmp_a = 8'(ca); cmp_b = 8'(ca + 3);
            ser_bit = 1'b0;
            go_mode(2'd2);
            gap(g, na, nb);
            repeat (2) begin
                gap(g, na, nb);
                chk(g == ca + 1, "R3 FSK half period A", g, ca + 1);
                chk(na == 1 && nb == 0, "R9 strobe A only", na * 10 + nb, 10);
            end
            ser_bit = 1'b1;
            gap(g, na, nb);
            repeat (2) begin
                gap(g, na, nb);
                chk(g == ca + 4, "R4 FSK half period B", g, ca + 4);
                chk(na == 0 && nb == 1, "R9 strobe B only", na * 10 + nb, 1);
            end
        end

        // R1 tick every other cycle
        cmp_a = 8'd3; ser_bit = 1'b0; slow = 1'b1;
        go_mode(2'd2);
        gap(g, na, nb);
        repeat (3) begin
            gap(g, na, nb);
            chk(g == 8, "R1 half period with slow tick", g, 8);
        end
        slow = 1'b0;

        // R2 toggle bit clear
        cfg_a = 3'b010;
        go_mode(2'd2);
        pv = mod_out; edges = 0; nma = 0;
        repeat (40) begin
            @(negedge clk);
            if (mod_out != pv) edges++;
            pv = mod_out;
            nma += int'(match_a);
        end
        chk(edges == 0, "R2 no toggle without toggle bit", edges, 0);
        chk(nma == 10, "R2 matches still counted", nma, 10);

        // R8 mid-period change
        cfg_a = 3'b011; cfg_b = 3'b011; cmp_a = 8'd5; cmp_b = 8'd2; ser_bit = 1'b0;
        go_mode(2'd2);
        gap(g, na, nb);
        repeat (2) @(negedge clk);
        ser_bit = 1'b1;
        gap(g, na, nb);
        chk(g == 4, "R8 current period unchanged", g, 4);
        gap(g, na, nb);
        chk(g == 3, "R8 next period uses new bit", g, 3);

        // R8 R4 alternating pattern, bit changed at every edge
        latched = 1;
        for (int i = 0; i < 8; i++) begin
            ser_bit = i[0];
            gap(g, na, nb);
            chk(g == (latched != 0 ? 3 : 6), "R4 alternating data", g, latched != 0 ? 3 : 6);
            latched = i & 1;
        end

        // R5 carrier burst
        cmp_a = 8'd2; cmp_b = 8'd7; ser_bit = 1'b1;
        go_mode(2'd1);
        gap(g, na, nb);
        repeat (3) begin
            gap(g, na, nb);
            chk(g == 3, "R5 carrier passes", g, 3);
        end
        ser_bit = 1'b0;
        repeat (10) @(negedge clk);
        hi = 0;
        repeat (40) begin
            @(negedge clk);
            hi += int'(mod_out);
        end
        chk(hi == 0, "R5 carrier gated off", hi, 0);

        // R6 R7 R8 pulse-width mode
        cmp_a = 8'd3; cmp_b = 8'd7; cfg_a = 3'b101; cfg_b = 3'b101;
        go_mode(2'd3);
        pwm_bit(1'b0, 1'b0, 3, 7);
        pwm_bit(1'b1, 1'b0, 3, 7);
        pwm_bit(1'b0, 1'b1, 3, 7);
        pwm_bit(1'b1, 1'b1, 3, 7);

        // R7 single action across counter overflow in FSK
        cfg_a = 3'b111; cmp_a = 8'd3; ser_bit = 1'b0;
        go_mode(2'd2);
        repeat (10) @(negedge clk);
        pulse_restart();
        pv = mod_out; edges = 0; nma = 0;
        repeat (600) begin
            @(negedge clk);
            if (mod_out != pv) edges++;
            pv = mod_out;
            nma += int'(match_a);
        end
        chk(edges == 1, "R7 single action edges", edges, 1);
        chk(nma == 1, "R7 single action strobes", nma, 1);

        // R10 reset mid-run and off mode
        cfg_a = 3'b011; cmp_a = 8'd1;
        go_mode(2'd2);
        repeat (7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!mod_out && !match_a && !match_b, "R10 reset mid-run", int'(mod_out), 0);
        rst = 1'b0;
        mode_sel = 2'd0;
        hi = 0;
        repeat (20) begin
            @(negedge clk);
            hi += int'(mod_out) + int'(match_a) + int'(match_b);
        end
        chk(hi == 0, "R10 off mode quiet", hi, 0);

        summary();
        $finish;
    end
endmodule